// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Step Unit

This block computes the next value of an address pointer for DSP data addressing. Each update takes the present pointer value, a signed step and a two-bit mode. It returns the stepped address one clock later. Three stepping schemes are provided:

- Plain linear stepping.
- Wrap-around stepping inside a circular buffer. The buffer is aligned to a power of two, and its length comes from an internal size register.
- Reverse-carry stepping, which walks an FFT data set in bit-reversed order.

The surrounding datapath feeds the pointer in, writes the size register whenever a new buffer is set up, and takes the result from the output register.

For a buffer length L held in the size register, the unit takes the smallest N with 2^N greater than L. The buffer base is the pointer with its N low bits cleared. The buffer covers base to base+L-1, and its end marker is the pointer with its N low bits replaced by those of L. In reverse-carry mode the step input plays the role of the index register, which holds half the transform size.

Top module: `addr_step_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, addr_o reads 0 and the size register holds 0.
- R2: addr_o changes only on the clock edge where upd_i is high, and it then shows the new address from the cycle after that edge. With upd_i low, addr_o keeps its value whatever the other inputs do.
- R3: Mode code 00 (linear) gives cur_i + step_i modulo 2^16, where step_i is two's complement, so both increment and decrement are possible.
- R4: A pulse on size_we_i loads size_i into the size register at that clock edge. An update on the same edge still uses the old size, and the new size applies to updates from the next edge on.
- R5: Mode code 01 (circular) with size L > 0 and N the smallest integer with 2^N > L: the bits of cur_i above bit N-1 pass through unchanged, and the low N bits of the result stay below L. This holds for pointers inside the buffer and |step_i| <= L.
- R6: In circular mode, when offset + step reaches L or more (offset = cur_i's low N bits), the result is base + (offset + step - L).
- R7: In circular mode, when offset + step is below 0, the result is base + (offset + step + L).
- R8: Mode code 10 (reverse-carry) adds step_i to cur_i with the carry running from bit 15 toward bit 0, and the carry out of bit 0 is dropped. With step_i = 2^(K-1), starting from 0 produces the bit-reversed sequence of a 2^K-point transform.
- R9: Mode code 11 is reserved: an update in that mode leaves addr_o unchanged.
- R10: In circular mode with a size register of 0, the step is linear, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_i | input | 1 | Update strobe |
| mode_i | input | 2 | Step mode: 00 linear, 01 circular, 10 reverse-carry, 11 reserved |
| cur_i | input | 16 | Present pointer value |
| step_i | input | 16 | Signed step, or half transform size in reverse-carry mode |
| size_we_i | input | 1 | Size register write strobe |
| size_i | input | 16 | Circular buffer length to load |
| addr_o | output | 16 | Registered next address |

## Verification
The size register is internal state, so a wrong value in it shows at the ports only on the next circular update. It then appears either as a wrap taken at the wrong offset or as a change to bits above the buffer window, in the cycle after that update. A fault in the reverse carry chain surfaces on the first reverse-carry update whose carry has to cross a bit, which in a bit-reversed walk is the second step. The bench compares addr_o with its own model after every clock, so a stale or spuriously updated output register is reported within one cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned ADDR_W = 16;

  typedef enum logic [1:0] {
    AM_LINEAR  = 2'b00,
    AM_RING    = 2'b01,
    AM_REVERSE = 2'b10,
    AM_RSVD    = 2'b11
  } amode_e;
endpackage

// File: rtl/ring_window.sv
// Holds the circular buffer length and derives the low-bit mask 2^N-1,
// with N the smallest integer such that 2^N exceeds the length.
module ring_window #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] len_o,
  output logic [AW-1:0] mask_o
);
  localparam int unsigned STG = $clog2(AW);

  logic [AW-1:0] len_q, len_d;
  logic [AW-1:0] smear;

  always_comb begin
    len_d = len_q;
    if (we_i) len_d = len_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  // Smear the top set bit downward: the result is 2^N-1 with 2^N > len.
  always_comb begin
    smear = len_q;
    for (int s = 0; s < STG; s++) smear = smear | (smear >> (1 << s));
  end

  assign len_o  = len_q;
  assign mask_o = smear;

  assert_len_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (len_q == $past(len_i)));

  assert_len_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(len_q));
endmodule

// File: rtl/ring_step.sv
// Circular-buffer step: offset inside an aligned window, wrapped by the length.
module ring_step #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] mask_i,
  output logic [AW-1:0] res_o
);
  localparam int unsigned SW = AW + 2;

  logic [AW-1:0]        base, offs, step_mag;
  logic signed [SW-1:0] sum_s, len_s, adj_s;

  always_comb begin
    base  = cur_i & ~mask_i;
    offs  = cur_i & mask_i;
    len_s = $signed({2'b00, len_i});
    sum_s = $signed({2'b00, offs}) + $signed({{2{step_i[AW-1]}}, step_i});
    if (sum_s < 0)           adj_s = sum_s + len_s;
    else if (sum_s >= len_s) adj_s = sum_s - len_s;
    else                     adj_s = sum_s;
    if (len_i == '0) res_o = cur_i + step_i;
    else             res_o = base | (adj_s[AW-1:0] & mask_i);
  end

  assign step_mag = step_i[AW-1] ? (~step_i + 1'b1) : step_i;

  // R5: a legal step from inside the buffer lands inside the buffer.
  always_comb begin
    if (len_i != '0 && offs < len_i && step_mag <= len_i) begin
      assert_ring_inside_R5: assert ((res_o & mask_i) < len_i);
    end
  end
endmodule

// File: rtl/revcarry_add.sv
// Adder whose carry ripples from the MSB toward the LSB.
module revcarry_add #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic [AW-1:0] s_o
);
  logic [AW:0] cy;

  assign cy[AW] = 1'b0;

  for (genvar i = AW - 1; i >= 0; i--) begin : g_bit
    assign s_o[i] = a_i[i] ^ b_i[i] ^ cy[i+1];
    assign cy[i]  = (a_i[i] & b_i[i]) | (cy[i+1] & (a_i[i] ^ b_i[i]));
  end

  always_comb begin
    if (b_i == '0) begin
      assert_rev_zero_step_R8: assert (s_o == a_i);
    end
  end
endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic              size_we_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] len_w, mask_w, ring_w, rev_w;
  logic [ADDR_W-1:0] addr_q, addr_d;
  amode_e            mode;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ring_window #(.AW(ADDR_W)) u_window (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_i   (size_we_i),
    .len_i  (size_i),
    .len_o  (len_w),
    .mask_o (mask_w)
  );

  ring_step #(.AW(ADDR_W)) u_ring (
    .cur_i  (cur_i),
    .step_i (step_i),
    .len_i  (len_w),
    .mask_i (mask_w),
    .res_o  (ring_w)
  );

  revcarry_add #(.AW(ADDR_W)) u_rev (
    .a_i (cur_i),
    .b_i (step_i),
    .s_o (rev_w)
  );

  assign mode = amode_e'(mode_i);

  always_comb begin
    addr_d = addr_q;
    if (upd_i) begin
      unique case (mode)
        AM_LINEAR:  addr_d = cur_i + step_i;
        AM_RING:    addr_d = ring_w;
        AM_REVERSE: addr_d = rev_w;
        AM_RSVD:    addr_d = addr_q;
        default:    addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) addr_q <= '0;
    else            addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !upd_i |=> $stable(addr_o));

  assert_linear_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd_i && mode_i == 2'b00) |=> (addr_o == $past(cur_i + step_i)));

  assert_ring_high_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd_i && mode_i == 2'b01 && len_w != '0)
      |=> ((addr_o & ~$past(mask_w)) == ($past(cur_i) & ~$past(mask_w))));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd_i && mode_i == 2'b11) |=> $stable(addr_o));
endmodule

// File: tb/addr_step_unit_test.sv
`timescale 1ns/1ps
module addr_step_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_i;
  logic [1:0]  mode_i;
  logic [15:0] cur_i, step_i, size_i;
  logic        size_we_i;
  logic [15:0] addr_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [15:0] exp_addr;
  int exp_len;

  always #2 clk = ~clk;

  addr_step_unit uut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .mode_i(mode_i), .cur_i(cur_i),
    .step_i(step_i), .size_we_i(size_we_i), .size_i(size_i), .addr_o(addr_o)
  );

  function automatic int win_mask(int len);
    int n = 0;
    while ((1 << n) <= len) n++;
    return (1 << n) - 1;
  endfunction

  function automatic logic [15:0] bitrev(logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [15:0] model_next(int mode, int cur, int stp, int len, logic [15:0] prev);
    int m, offs, s;
    logic [15:0] sum;
    case (mode)
      0: return 16'(cur + stp);
      1: begin
        if (len == 0) return 16'(cur + stp);
        m = win_mask(len);
        offs = cur & m;
        s = offs + stp;
        if (s < 0) s = s + len;
        else if (s >= len) s = s - len;
        return 16'((cur & ~m) + s);
      end
      2: begin
        sum = bitrev(16'(cur)) + bitrev(16'(stp));
        return bitrev(sum);
      end
      default: return prev;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, got, exp);
    end
  endtask

  // One clock: drive at negedge, advance the model at posedge, compare at next negedge.
  task automatic cycle(string tag, bit upd, int mode, int cur, int stp, bit we = 0, int len = 0);
    upd_i = upd; mode_i = 2'(mode); cur_i = 16'(cur); step_i = 16'(stp);
    size_we_i = we; size_i = 16'(len);
    @(posedge clk);
    if (upd) exp_addr = model_next(mode, cur, stp, exp_len, exp_addr);
    if (we) exp_len = len;
    @(negedge clk);
    check(tag, addr_o, exp_addr);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected=<5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int seq [8] = '{0, 4, 2, 6, 1, 5, 3, 7};

  initial begin
    rst_n = 1'b0; upd_i = 0; mode_i = 0; cur_i = 16'h5555; step_i = 16'h1;
    size_we_i = 0; size_i = 0;
    exp_addr = 0; exp_len = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", addr_o, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", addr_o, 16'h0);
    // R1: size register starts at 0, so circular behaves linearly
    cycle("R1 R10 size zero", 1, 1, 16'h2000, -1);

    cycle("R3 increment", 1, 0, 100, 5);
    cycle("R3 decrement wrap", 1, 0, 3, -5);
    cycle("R2 idle hold", 0, 0, 16'h7777, 9);
    cycle("R2 idle hold rev", 0, 2, 16'h1111, 1);

    cycle("R4 load ten", 0, 1, 0, 0, 1, 10);
    cycle("R5 inside", 1, 1, 16'h1234, 3);
    cycle("R6 forward wrap", 1, 1, 16'h1234, 6);
    cycle("R6 end wrap", 1, 1, 16'h1239, 1);
    cycle("R7 backward wrap", 1, 1, 16'h1231, -3);
    cycle("R7 zero minus one", 1, 1, 16'h1230, -1);

    cycle("R4 old size same edge", 1, 1, 16'h1235, 4, 1, 6);
    cycle("R4 new size next edge", 1, 1, 16'h1235, 4);

    cycle("R4 load sixteen", 0, 1, 0, 0, 1, 16);
    cycle("R5 window N=5", 1, 1, 16'h0047, 12);
    cycle("R5 high bits kept", 1, 1, 16'hABCF, 1);

    cycle("R4 load zero", 0, 1, 0, 0, 1, 0);
    cycle("R10 zero size linear", 1, 1, 16'h2000, -1);

    // R8: 8-point bit-reversed walk with half size 4
    cycle("R8 start", 1, 0, 0, 0);
    for (int k = 1; k < 9; k++) begin
      cycle("R8 fft walk", 1, 2, exp_addr, 4);
      check("R8 fft order", addr_o, 16'(seq[k % 8]));
    end
    cycle("R8 carry out dropped", 1, 2, 16'hFFFF, 1);
    cycle("R8 top bit carry", 1, 2, 16'h8000, 16'h8000);

    cycle("R9 reserved", 1, 3, 16'h4321, 7);
    cycle("R9 reserved again", 1, 3, 16'h0000, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule